// File: doc/BRIEF.md
# Register-Indirect Conditional Branch and Link Resolver

This block resolves one register-indirect branch per cycle. It takes a fetched 32-bit instruction word and the three operand values a register file returns: the jump destination, the value under test and the already incremented program counter. It decides whether the branch is taken and produces the next program counter. It also produces a write-back request that stores the return address into a link register.

The block is purely combinational. It decodes the destination and test register selectors from the instruction, so the surrounding register file can return the operand values. The link destination selector is passed out with the write request. Two opcodes are recognised: a plain conditional jump and a jump that also records a return address. A three-bit code in the lowest instruction bits chooses the condition tested on the test operand. Every other opcode passes the incremented program counter straight through and requests nothing.

Top module: `branch_link_resolve`

## Requirements
- R1: The selectors are decoded from fixed instruction fields. `tgt_sel` is instruction bits 21..17, `test_sel` is bits 16..12 and `link_sel` is bits 26..22. This holds for every opcode.
- R2: Only opcode 8 (plain jump) and opcode 9 (jump with link) act. The opcode is instruction bits 31..27. For any other opcode `taken` and `link_we` are 0 and `next_pc` equals `pc_inc`.
- R3: The condition code is instruction bits 2..0. Code 000 never jumps and code 001 always jumps. Code 010 jumps when `test_val` is zero, and code 011 jumps when it is nonzero. Code 100 jumps when `test_val` bit 31 is 0, and code 101 jumps when that bit is 1. Codes 110 and 111 never jump.
- R4: When the jump is taken, `taken` is 1 and `next_pc` equals `tgt_val`.
- R5: When the jump is not taken, `taken` is 0 and `next_pc` equals `pc_inc`.
- R6: For opcode 9, `link_we` is 1 and `link_data` equals `pc_inc`, whether or not the jump is taken.
- R7: Opcode 9 with code 000 only stores the return address. `link_we` is 1, `taken` is 0 and `next_pc` equals `pc_inc`.
- R8: Opcode 8 never raises `link_we`.
- R9: Instruction bits 11..3 have no effect on `taken`, `next_pc`, `link_we` or `link_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word being executed |
| tgt_val | input | 32 | Value read at `tgt_sel`: the jump destination |
| test_val | input | 32 | Value read at `test_sel`: the operand tested |
| pc_inc | input | 32 | Program counter already advanced past this instruction |
| tgt_sel | output | 5 | Register index of the jump destination |
| test_sel | output | 5 | Register index of the tested operand |
| link_sel | output | 5 | Register index receiving the return address |
| link_we | output | 1 | Request to write `link_data` to `link_sel` |
| link_data | output | 32 | Return address to store |
| taken | output | 1 | Jump is taken |
| next_pc | output | 32 | Program counter for the following instruction |

## Verification
The assertions assume fully known input values. They also assume `tgt_val` and `test_val` were read at the selectors the block itself decodes, so the checks relate outputs only to the port values and never to register contents. The bench drives every input to a defined value one time unit after a rising edge and compares at the falling edge. Its operand patterns include zero, the sign boundary and values with only bit 31 set, so that the zero and sign tests are separated.

// File: rtl/branch_link_resolve.sv
module branch_link_resolve #(
  parameter int XLEN   = 32,
  parameter int OP_JMP = 8,
  parameter int OP_JAL = 9
) (
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] tgt_val,
  input  logic [XLEN-1:0] test_val,
  input  logic [XLEN-1:0] pc_inc,
  output logic [4:0]      tgt_sel,
  output logic [4:0]      test_sel,
  output logic [4:0]      link_sel,
  output logic            link_we,
  output logic [XLEN-1:0] link_data,
  output logic            taken,
  output logic [XLEN-1:0] next_pc
);
  localparam int SIGN = XLEN - 1;

  logic [4:0] opcode;
  logic [2:0] cc;
  logic       is_jmp, is_jal, cond_ok;

  assign opcode   = instr[31:27];
  assign link_sel = instr[26:22];
  assign tgt_sel  = instr[21:17];
  assign test_sel = instr[16:12];
  assign cc       = instr[2:0];

  assign is_jmp = (opcode == 5'(OP_JMP));
  assign is_jal = (opcode == 5'(OP_JAL));

  always_comb begin
    unique case (cc)
      3'b001:  cond_ok = 1'b1;
      3'b010:  cond_ok = (test_val == '0);
      3'b011:  cond_ok = (test_val != '0);
      3'b100:  cond_ok = ~test_val[SIGN];
      3'b101:  cond_ok = test_val[SIGN];
      default: cond_ok = 1'b0;
    endcase
  end

  assign taken     = (is_jmp | is_jal) & cond_ok;
  assign next_pc   = taken ? tgt_val : pc_inc;
  assign link_we   = is_jal;
  assign link_data = pc_inc;

  always_comb begin
    p_target_r4: assert (!taken || next_pc == tgt_val);
    p_fallthru_r5: assert (taken || next_pc == pc_inc);
    p_link_value_r6: assert (!link_we || link_data == pc_inc);
    p_jmp_nolink_r8: assert (!(instr[31:27] == 5'(OP_JMP)) || !link_we);
    p_other_idle_r2: assert ((instr[31:27] == 5'(OP_JMP)) || (instr[31:27] == 5'(OP_JAL)) || (!taken && !link_we));
    p_never_r3: assert (!(instr[2:0] == 3'b000 || instr[2:1] == 2'b11) || !taken);
  end
endmodule

// File: tb/test_branch_link_resolve.sv
module test_branch_link_resolve;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] instr, tgt_val, test_val, pc_inc;
  logic [4:0]  tgt_sel, test_sel, link_sel;
  logic        link_we, taken;
  logic [31:0] link_data, next_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  branch_link_resolve i_branch_link_resolve (
    .instr(instr), .tgt_val(tgt_val), .test_val(test_val), .pc_inc(pc_inc),
    .tgt_sel(tgt_sel), .test_sel(test_sel), .link_sel(link_sel),
    .link_we(link_we), .link_data(link_data), .taken(taken), .next_pc(next_pc)
  );

  function automatic logic [31:0] mk(int op, int ra, int rb, int rc, int cc, int mid);
    logic [31:0] w;
    w = 32'd0;
    w[31:27] = 5'(op); w[26:22] = 5'(ra); w[21:17] = 5'(rb);
    w[16:12] = 5'(rc); w[11:3] = 9'(mid); w[2:0] = 3'(cc);
    return w;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] w, logic [31:0] t, logic [31:0] v, logic [31:0] p, string req);
    int op, cc;
    bit go, lnk;
    @(posedge clk);
    #1;
    instr = w; tgt_val = t; test_val = v; pc_inc = p;
    @(negedge clk);
    op = int'(w >> 27);
    cc = int'(w & 7);
    go = 0;
    if (op == 8 || op == 9) begin
      if (cc == 1) go = 1;
      else if (cc == 2) go = (v == 0);
      else if (cc == 3) go = (v != 0);
      else if (cc == 4) go = (v < 32'h8000_0000);
      else if (cc == 5) go = (v >= 32'h8000_0000);
    end
    lnk = (op == 9);
    chk(req, "taken", {31'd0, taken}, {31'd0, go});
    chk(req, "next_pc", next_pc, go ? t : p);
    chk(req, "link_we", {31'd0, link_we}, {31'd0, lnk});
    if (lnk) chk(req, "link_data", link_data, p);
    chk("R1", "tgt_sel", {27'd0, tgt_sel}, (w >> 17) & 31);
    chk("R1", "test_sel", {27'd0, test_sel}, (w >> 12) & 31);
    chk("R1", "link_sel", {27'd0, link_sel}, (w >> 22) & 31);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    instr = 0; tgt_val = 0; test_val = 0; pc_inc = 0;
    apply(32'd0, 32'h0, 32'h0, 32'h0, "R2");
    apply(mk(8, 3, 7, 11, 1, 0), 32'h0000_4000, 32'h5, 32'h104, "R4");
    apply(mk(8, 0, 5, 1, 0, 0), 32'h0000_4000, 32'h0, 32'h104, "R3");
    apply(mk(8, 0, 5, 1, 2, 0), 32'h0000_8000, 32'h0, 32'h200, "R3");
    apply(mk(8, 0, 5, 1, 2, 0), 32'h0000_8000, 32'h1, 32'h200, "R5");
    apply(mk(8, 0, 1, 0, 3, 0), 32'hA000_0000, 32'h8000_0000, 32'h300, "R3");
    apply(mk(8, 0, 1, 0, 3, 0), 32'hA000_0000, 32'h0, 32'h300, "R5");
    apply(mk(8, 0, 3, 2, 4, 0), 32'h1234_5678, 32'h7FFF_FFFF, 32'h400, "R3");
    apply(mk(8, 0, 3, 2, 4, 0), 32'h1234_5678, 32'h8000_0000, 32'h400, "R3");
    apply(mk(8, 0, 3, 2, 5, 0), 32'h1234_5678, 32'h8000_0000, 32'h400, "R3");
    apply(mk(8, 0, 3, 2, 5, 0), 32'h1234_5678, 32'h0, 32'h400, "R3");
    apply(mk(8, 0, 3, 2, 6, 0), 32'h1234_5678, 32'h0, 32'h400, "R3");
    apply(mk(9, 0, 3, 2, 7, 0), 32'h1234_5678, 32'h1, 32'h404, "R3");
    apply(mk(9, 6, 0, 0, 0, 0), 32'hDEAD_BEEC, 32'h0, 32'h508, "R7");
    apply(mk(9, 6, 4, 0, 1, 0), 32'hDEAD_BEEC, 32'h0, 32'h50C, "R6");
    apply(mk(9, 7, 5, 1, 2, 0), 32'h0000_0040, 32'h9, 32'h510, "R6");
    apply(mk(8, 7, 5, 1, 1, 0), 32'h0000_0040, 32'h9, 32'h514, "R8");
    apply(mk(12, 2, 3, 4, 1, 0), 32'h0000_0040, 32'h0, 32'h518, "R2");
    apply(mk(10, 2, 3, 4, 1, 0), 32'h0000_0040, 32'h0, 32'h518, "R2");
    apply(mk(31, 31, 31, 31, 1, 511), 32'hFFFF_FFFC, 32'h0, 32'h51C, "R2");
    apply(mk(8, 0, 5, 1, 2, 511), 32'h0000_8000, 32'h0, 32'h200, "R9");
    apply(mk(9, 1, 5, 1, 3, 170), 32'h0000_8000, 32'h0, 32'h204, "R9");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w, v;
      w = $urandom;
      if (i % 2 == 0) w[31:27] = 5'(8 + (i % 4 == 0 ? 1 : 0));
      v = $urandom;
      if (i % 5 == 0) v = 0;
      if (i % 7 == 0) v = 32'h8000_0000;
      apply(w, $urandom, v, $urandom, "R3");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule